// File: doc/BRIEF.md
# Loopback and Diagnostic Path Control

This block sits between the encoder, the decoder, the line-side mark streams and the receive terminal interface of a single-channel line interface. It decides which mark stream goes out to the line driver, which stream feeds the decoder, and what the receive terminal pins show. The line is modelled as a pair of digital mark rails: one positive, one negative. The block supports three loopbacks, all-ones insertion in both directions, an alarm test override and muting of the receive outputs when the signal is lost.

Every control input is registered once. All path selection is combinational logic on those registered controls. A change of mode therefore shows on the outputs after the next rising clock edge. Data streams pass through without a register.

Top module: `lpbk_diag_ctrl`

## Requirements
- R1: Every control input is captured on the rising clock edge, and the outputs follow the new mode from that edge on. Reset clears all modes: no loopback, no insertion, no mute, no alarm test, single-rail. With no mode set, the line output carries the encoder marks and the decoder input carries the received line marks.
- R2: While the local loopback enable is low, the decoder input equals the marks sent to the line, and the received line marks are ignored. Local loopback overrides remote and digital loopback, so the line output keeps carrying encoder marks even when remote loopback is also requested.
- R3: While the remote loopback enable is low and local loopback is off, the line output carries the received line marks and the encoder marks are ignored. The received marks still reach the decoder input.
- R4: While the digital loopback enable is low and local loopback is off, the decoder input carries the encoder marks and the received line marks are ignored.
- R5: A transmit all-ones request sends alternating single marks to the line. The first cycle after the request is captured carries a positive mark, and the polarity flips every cycle after that. This request overrides remote loopback.
- R6: A receive all-ones request without mute puts all marks on the receive terminal outputs and drives the receive clock from the master clock input. The decoder data is ignored, so the request overrides digital loopback. Output levels by mode: in dual-rail normal polarity both rails are 1; in dual-rail inverted polarity both rails are 0; in single-rail the data is 1 and the violation flag is 0.
- R7: While the alarm test input (active low) is asserted, both alarm outputs are low. In single-rail mode the violation output is also forced high. Data outputs in dual-rail mode are not changed.
- R8: Outside alarm test, the signal-loss output (active low) is the inverse of the loss input. The clock-loss output (active low) goes low only when mute is enabled and loss is present.
- R9: When mute is enabled and loss is present, the receive outputs take fixed values. Dual-rail normal polarity: clock 1, both rails 0. Dual-rail inverted polarity: clock 0, both rails 1. Single-rail: clock 1, data 0, violation 0. Mute overrides receive all-ones.
- R10: Without mute or all-ones, in dual-rail mode the receive rails carry the decoder's positive and negative marks, inverted when the polarity select is high. In single-rail mode the positive output carries decoder data, the negative output carries the violation flag, and the polarity select is ignored. The receive clock follows the recovered clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| loc_lb_n | input | 1 | Local loopback enable, active low |
| rem_lb_n | input | 1 | Remote loopback enable, active low |
| dig_lb_n | input | 1 | Digital loopback enable, active low |
| tx_ones_req | input | 1 | Transmit all-ones request |
| rx_ones_req | input | 1 | Receive all-ones request |
| alm_test_n | input | 1 | Alarm test, active low |
| mute_en | input | 1 | Mute receive outputs on loss |
| los_in | input | 1 | Loss of signal present |
| dual_rail | input | 1 | 1 = dual-rail terminal format |
| inv_pol | input | 1 | 1 = active-low terminal rails (dual-rail only) |
| mclk_in | input | 1 | Master clock level used during all-ones insertion |
| enc_p | input | 1 | Encoder positive mark |
| enc_n | input | 1 | Encoder negative mark |
| line_rx_p | input | 1 | Received line positive mark |
| line_rx_n | input | 1 | Received line negative mark |
| dcd_p | input | 1 | Decoder positive mark / single-rail data |
| dcd_n | input | 1 | Decoder negative mark |
| dcd_lcv | input | 1 | Decoder code violation flag |
| rclk_in | input | 1 | Recovered clock level |
| line_tx_p | output | 1 | Positive mark to line driver |
| line_tx_n | output | 1 | Negative mark to line driver |
| dec_in_p | output | 1 | Positive mark to decoder |
| dec_in_n | output | 1 | Negative mark to decoder |
| rx_out_p | output | 1 | Receive terminal positive rail / data |
| rx_out_n | output | 1 | Receive terminal negative rail / violation |
| rx_clk_o | output | 1 | Receive terminal clock |
| clk_loss_n | output | 1 | Clock-loss alarm, active low |
| sig_loss_n | output | 1 | Signal-loss alarm, active low |

## Verification
The bench focuses on overlapping requests. It combines local with remote and digital loopback, and transmit all-ones with remote loopback. A wrong priority shows up as received marks leaking to the line or the decoder. It runs mute and all-ones together in all three output formats: a design that puts insertion ahead of mute drives marks where fixed idle levels are required, and a design that ignores polarity gets the clock and rail levels inverted. It also sets alarm test in both rail modes, and checks that the first all-ones mark is positive and that the marks alternate. Any mode switch applied one cycle early or late shows up as a mismatch on the reference comparison made every cycle.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

    // Registered mode word, all fields active high inside the block
    typedef struct packed {
        logic loc;
        logic rem;
        logic dig;
        logic txo;
        logic rxo;
        logic atest;
        logic mute;
        logic los;
        logic dual;
        logic inv;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic p;
        logic n;
    } rail_t;

    // AMI mark for the all-ones pattern: phase 0 gives a positive mark
    function automatic rail_t ones_mark(input logic phase);
        rail_t r;
        r.p = ~phase;
        r.n = phase;
        return r;
    endfunction

    function automatic rail_t rail_pol(input rail_t r, input logic inv);
        rail_t o;
        o.p = r.p ^ inv;
        o.n = r.n ^ inv;
        return o;
    endfunction

endpackage

// File: rtl/lbd_ctrl_reg.sv
module lbd_ctrl_reg
    import lbd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  loc_lb_n,
    input  logic  rem_lb_n,
    input  logic  dig_lb_n,
    input  logic  tx_ones_req,
    input  logic  rx_ones_req,
    input  logic  alm_test_n,
    input  logic  mute_en,
    input  logic  los_in,
    input  logic  dual_rail,
    input  logic  inv_pol,
    output ctrl_t ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.loc   = ~loc_lb_n;
        ctrl_d.rem   = ~rem_lb_n;
        ctrl_d.dig   = ~dig_lb_n;
        ctrl_d.txo   = tx_ones_req;
        ctrl_d.rxo   = rx_ones_req;
        ctrl_d.atest = ~alm_test_n;
        ctrl_d.mute  = mute_en;
        ctrl_d.los   = los_in;
        ctrl_d.dual  = dual_rail;
        ctrl_d.inv   = inv_pol;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/lbd_route.sv
module lbd_route
    import lbd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  rail_t enc,
    input  rail_t line_rx,
    output rail_t line_tx,
    output rail_t dec_in
);

    logic ph_q;

    // Phase of the alternating all-ones pattern; restarts positive
    always_ff @(posedge clk) begin
        if (rst)           ph_q <= 1'b0;
        else if (ctrl.txo) ph_q <= ~ph_q;
        else               ph_q <= 1'b0;
    end

    // Transmit side: insertion > remote (unless local) > encoder
    always_comb begin
        if (ctrl.txo)                    line_tx = ones_mark(ph_q);
        else if (ctrl.rem && !ctrl.loc)  line_tx = line_rx;
        else                             line_tx = enc;
    end

    // Decoder side: local > digital > line
    always_comb begin
        if (ctrl.loc)      dec_in = line_tx;
        else if (ctrl.dig) dec_in = enc;
        else               dec_in = line_rx;
    end

endmodule

// File: rtl/lbd_rx_out.sv
module lbd_rx_out
    import lbd_pkg::*;
(
    input  ctrl_t ctrl,
    input  rail_t dcd,
    input  logic  dcd_lcv,
    input  logic  rclk_in,
    input  logic  mclk_in,
    output rail_t rx_out,
    output logic  rx_clk_o,
    output logic  clk_loss_n,
    output logic  sig_loss_n
);

    logic  muted;
    logic  act_inv;
    rail_t base;
    logic  lcv_val;

    assign muted   = ctrl.mute & ctrl.los;
    assign act_inv = ctrl.dual & ctrl.inv;

    always_comb begin
        base    = '0;
        lcv_val = 1'b0;
        if (muted) begin
            rx_clk_o = ~act_inv;
            base     = '0;
        end else if (ctrl.rxo) begin
            rx_clk_o = mclk_in;
            base     = '{p: 1'b1, n: ctrl.dual};
        end else begin
            rx_clk_o = rclk_in;
            base     = dcd;
            lcv_val  = dcd_lcv;
        end

        if (ctrl.dual) begin
            rx_out = rail_pol(base, ctrl.inv);
        end else begin
            rx_out.p = base.p;
            rx_out.n = lcv_val | ctrl.atest;
        end
    end

    assign sig_loss_n = ~(ctrl.atest | ctrl.los);
    assign clk_loss_n = ~(ctrl.atest | muted);

endmodule

// File: rtl/lpbk_diag_ctrl.sv
module lpbk_diag_ctrl
    import lbd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic loc_lb_n,
    input  logic rem_lb_n,
    input  logic dig_lb_n,
    input  logic tx_ones_req,
    input  logic rx_ones_req,
    input  logic alm_test_n,
    input  logic mute_en,
    input  logic los_in,
    input  logic dual_rail,
    input  logic inv_pol,
    input  logic mclk_in,
    input  logic enc_p,
    input  logic enc_n,
    input  logic line_rx_p,
    input  logic line_rx_n,
    input  logic dcd_p,
    input  logic dcd_n,
    input  logic dcd_lcv,
    input  logic rclk_in,
    output logic line_tx_p,
    output logic line_tx_n,
    output logic dec_in_p,
    output logic dec_in_n,
    output logic rx_out_p,
    output logic rx_out_n,
    output logic rx_clk_o,
    output logic clk_loss_n,
    output logic sig_loss_n
);

    ctrl_t ctrl_q;
    rail_t enc, line_rx, dcd, line_tx, dec_in, rx_out;

    assign enc     = '{p: enc_p,     n: enc_n};
    assign line_rx = '{p: line_rx_p, n: line_rx_n};
    assign dcd     = '{p: dcd_p,     n: dcd_n};

    lbd_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst),
        .loc_lb_n(loc_lb_n), .rem_lb_n(rem_lb_n), .dig_lb_n(dig_lb_n),
        .tx_ones_req(tx_ones_req), .rx_ones_req(rx_ones_req),
        .alm_test_n(alm_test_n), .mute_en(mute_en), .los_in(los_in),
        .dual_rail(dual_rail), .inv_pol(inv_pol),
        .ctrl_q(ctrl_q)
    );

    lbd_route u_route (
        .clk(clk), .rst(rst), .ctrl(ctrl_q),
        .enc(enc), .line_rx(line_rx),
        .line_tx(line_tx), .dec_in(dec_in)
    );

    lbd_rx_out u_rx (
        .ctrl(ctrl_q), .dcd(dcd), .dcd_lcv(dcd_lcv),
        .rclk_in(rclk_in), .mclk_in(mclk_in),
        .rx_out(rx_out), .rx_clk_o(rx_clk_o),
        .clk_loss_n(clk_loss_n), .sig_loss_n(sig_loss_n)
    );

    assign line_tx_p = line_tx.p;
    assign line_tx_n = line_tx.n;
    assign dec_in_p  = dec_in.p;
    assign dec_in_n  = dec_in.n;
    assign rx_out_p  = rx_out.p;
    assign rx_out_n  = rx_out.n;

    AST_TX_ONES_SINGLE_MARK: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.txo |-> (line_tx_p ^ line_tx_n)); // R5
    AST_TX_ONES_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.txo && $past(ctrl_q.txo)) |-> (line_tx_p != $past(line_tx_p))); // R5
    AST_LOCAL_FEEDS_DECODER: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.loc |-> (dec_in_p == line_tx_p && dec_in_n == line_tx_n)); // R2
    AST_LOCAL_BLOCKS_REMOTE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.loc && !ctrl_q.txo) |-> (line_tx_p == enc_p && line_tx_n == enc_n)); // R2
    AST_ALARM_TEST_LOW: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.atest |-> (!clk_loss_n && !sig_loss_n)); // R7
    AST_MUTE_CLOCK_LOSS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mute && ctrl_q.los) |-> !clk_loss_n); // R9
    AST_RX_ONES_DUAL: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rxo && !(ctrl_q.mute && ctrl_q.los) && ctrl_q.dual && !ctrl_q.inv)
        |-> (rx_out_p && rx_out_n)); // R6

endmodule

// File: tb/test_lpbk_diag_ctrl.sv
`timescale 1ns/1ps
module test_lpbk_diag_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loc_lb_n = 1, rem_lb_n = 1, dig_lb_n = 1;
    logic tx_ones_req = 0, rx_ones_req = 0, alm_test_n = 1;
    logic mute_en = 0, los_in = 0, dual_rail = 0, inv_pol = 0;
    logic mclk_in = 0, enc_p = 0, enc_n = 0, line_rx_p = 0, line_rx_n = 0;
    logic dcd_p = 0, dcd_n = 0, dcd_lcv = 0, rclk_in = 0;
    logic line_tx_p, line_tx_n, dec_in_p, dec_in_n;
    logic rx_out_p, rx_out_n, rx_clk_o, clk_loss_n, sig_loss_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    lpbk_diag_ctrl i_lpbk_diag_ctrl (.*);

    // Reference model state: controls as seen after the last edge
    bit m_loc, m_rem, m_dig, m_txo, m_rxo, m_at, m_mute, m_los, m_dual, m_inv;
    bit m_ph;

    always @(posedge clk) begin
        if (rst) begin
            {m_loc, m_rem, m_dig, m_txo, m_rxo, m_at, m_mute, m_los, m_dual, m_inv} = '0;
            m_ph = 0;
        end else begin
            m_ph   = m_txo ? !m_ph : 1'b0;
            m_loc  = !loc_lb_n;  m_rem = !rem_lb_n;  m_dig = !dig_lb_n;
            m_txo  = tx_ones_req; m_rxo = rx_ones_req; m_at = !alm_test_n;
            m_mute = mute_en; m_los = los_in; m_dual = dual_rail; m_inv = inv_pol;
        end
    end

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        bit tp, tn, dp, dn, rp, rn, rc, muted;
        string ttag, dtag, rtag, atag;
        if (m_txo)                 begin tp = !m_ph; tn = m_ph; ttag = "R5"; end
        else if (m_rem && !m_loc)  begin tp = line_rx_p; tn = line_rx_n; ttag = "R3"; end
        else                       begin tp = enc_p; tn = enc_n; ttag = m_loc ? "R2" : "R1"; end
        if (m_loc)      begin dp = tp; dn = tn; dtag = "R2"; end
        else if (m_dig) begin dp = enc_p; dn = enc_n; dtag = "R4"; end
        else            begin dp = line_rx_p; dn = line_rx_n; dtag = "R1"; end
        muted = m_mute && m_los;
        if (muted) begin
            rtag = "R9";
            rc = !(m_dual && m_inv);
            rp = m_dual && m_inv;
            rn = m_dual ? m_inv : m_at;
        end else if (m_rxo) begin
            rtag = "R6";
            rc = mclk_in;
            rp = m_dual ? !m_inv : 1'b1;
            rn = m_dual ? !m_inv : m_at;
        end else begin
            rtag = "R10";
            rc = rclk_in;
            rp = m_dual ? (dcd_p ^ m_inv) : dcd_p;
            rn = m_dual ? (dcd_n ^ m_inv) : (dcd_lcv | m_at);
        end
        if (m_at && !m_dual && !muted) rtag = "R7";
        atag = m_at ? "R7" : "R8";
        chk(ttag, "line_tx_p", line_tx_p, tp);
        chk(ttag, "line_tx_n", line_tx_n, tn);
        chk(dtag, "dec_in_p", dec_in_p, dp);
        chk(dtag, "dec_in_n", dec_in_n, dn);
        chk(rtag, "rx_out_p", rx_out_p, rp);
        chk(rtag, "rx_out_n", rx_out_n, rn);
        chk(rtag, "rx_clk_o", rx_clk_o, rc);
        chk(atag, "sig_loss_n", sig_loss_n, m_at ? 1'b0 : !m_los);
        chk(atag, "clk_loss_n", clk_loss_n, m_at ? 1'b0 : !muted);
    endtask

    task automatic drive_data();
        {mclk_in, enc_p, enc_n, line_rx_p, line_rx_n, dcd_p, dcd_n, dcd_lcv, rclk_in} = 9'($urandom);
    endtask

    // Hold one mode word for a number of cycles, comparing every cycle
    task automatic run_mode(input bit loc, rem, dig, txo, rxo, at, mute, los, dual, inv, input int cyc);
        loc_lb_n = !loc; rem_lb_n = !rem; dig_lb_n = !dig;
        tx_ones_req = txo; rx_ones_req = rxo; alm_test_n = !at;
        mute_en = mute; los_in = los; dual_rail = dual; inv_pol = inv;
        for (int i = 0; i < cyc; i++) begin
            drive_data();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        run_mode(1,1,1,1,1,1,1,1,1,1, 0);
        @(negedge clk); @(negedge clk);
        // R1: during reset the mode word is cleared even with all requests set
        for (int i = 0; i < 3; i++) begin drive_data(); @(negedge clk); compare(); end
        rst = 0;
        //           loc rem dig txo rxo at mute los dual inv
        run_mode(0,0,0,0,0,0,0,0,0,0, 12);   // R1 idle single-rail
        run_mode(0,0,0,0,0,0,0,0,1,0, 12);   // R10 dual normal
        run_mode(0,0,0,0,0,0,0,0,1,1, 12);   // R10 dual inverted
        run_mode(0,0,0,0,0,0,0,0,0,1, 12);   // R10 polarity ignored single
        run_mode(1,0,0,0,0,0,0,0,0,0, 12);   // R2 local
        run_mode(1,1,1,0,0,0,0,0,1,0, 12);   // R2 local beats remote and digital
        run_mode(0,1,0,0,0,0,0,0,0,0, 12);   // R3 remote
        run_mode(0,0,1,0,0,0,0,0,0,0, 12);   // R4 digital
        run_mode(0,1,1,0,0,0,0,0,1,0, 12);   // R3 R4 together
        run_mode(0,1,0,1,0,0,0,0,0,0, 13);   // R5 tx ones over remote
        run_mode(0,0,0,0,0,0,0,0,0,0, 2);
        run_mode(1,0,0,1,0,0,0,0,0,0, 9);    // R5 restarts positive, looped
        run_mode(0,0,1,0,1,0,0,0,1,0, 12);   // R6 over digital, dual normal
        run_mode(0,0,0,0,1,0,0,0,1,1, 12);   // R6 dual inverted
        run_mode(0,0,0,0,1,0,0,0,0,0, 12);   // R6 single
        run_mode(0,0,0,0,0,1,0,0,0,0, 12);   // R7 single-rail
        run_mode(0,0,0,0,0,1,0,1,1,0, 12);   // R7 dual, data untouched
        run_mode(0,0,0,0,0,0,0,1,1,0, 12);   // R8 loss without mute
        run_mode(0,0,0,0,0,0,1,0,1,0, 12);   // R8 mute without loss
        run_mode(0,0,0,0,1,0,1,1,1,0, 12);   // R9 dual normal, beats ones
        run_mode(0,0,0,0,1,0,1,1,1,1, 12);   // R9 dual inverted
        run_mode(0,0,0,0,0,0,1,1,0,0, 12);   // R9 single
        run_mode(0,0,0,0,0,1,1,1,0,0, 12);   // R9 with R7 single
        // R1: toggle modes every cycle to exercise capture timing
        for (int k = 0; k < 150; k++) begin
            bit [9:0] w = 10'($urandom);
            run_mode(w[0],w[1],w[2],w[3],w[4],w[5],w[6],w[7],w[8],w[9], 1 + (k % 3));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule